// File: doc/BRIEF.md
# Cascadable Programmable Tap-Delay Stage

This block delays a single-bit signal by a programmable number of clock cycles. One cycle stands for one quarter of a basic gate delay. The input first passes an enable gate, then enters a shift chain, and a tap multiplexer picks the chain position that drives the output. A stored 7-bit select code chooses that position. The low two code bits carry fractional weights: one cycle for bit 0 and two cycles for bit 1. Bits 2 to 6 weigh 4, 8, 16, 32 and 64 cycles.

The select code and an extra cascade bit are captured in a holding register. The register loads on every clock edge where the load-enable input is high and keeps its value otherwise. Two override inputs write fixed patterns into the register. One forces the shortest setting. The other forces the longest setting, which is one step beyond the all-ones code, so the delay stays monotonic.

The stored cascade bit appears on a true and complement output pair. To chain stages, the first stage's true output drives its own maximum override, and its complement drives the next stage's minimum override. All stages share the 7-bit select bus. Each added stage costs one extra cascade line.

Top module: `tapDelayStage`

## Requirements
- R1: While `rstN` is low, `sigOut` and `cascOut` are 0 and `cascOutN` is 1. After reset the stage holds the zero setting, so its latency is 2 cycles.
- R2: With `sigEn` high, a value presented on `sigIn` appears on `sigOut` exactly 2 + U cycles later. U is the stored code read as an unsigned binary number: bit 0 weighs 1 cycle, bit 1 weighs 2 cycles, and bits 2..6 weigh 4..64 cycles.
- R3: `selCode` and `cascSel` are captured at each rising edge where `latchEn` is 1. While `latchEn` is 0, changes on either input leave the latency and `cascOut` unchanged.
- R4: `forceMin` clears every stored bit, including the cascade bit, giving U = 0. The cleared state remains after `forceMin` falls, until the next load.
- R5: `forceMax` stores code bits 1:0 = 00 and bits 6:2 = 11111, and adds 4 extra cycles, giving U = 128. It leaves the stored cascade bit unchanged. This setting also remains after release, until the next load or `forceMin`.
- R6: `forceMin` takes priority over `forceMax`, and both take priority over `latchEn`. While either override is high, the select bus and `cascSel` have no effect.
- R7: `cascOut` equals the stored cascade bit and `cascOutN` is its inverse.
- R8: A `sigIn` sample taken while `sigEn` is 0 enters the chain as 0. Samples already in the chain keep moving toward the output.
- R9: The maximum setting (U = 128) is exactly one cycle longer than the all-ones code (U = 127). Two stages chained as described have latency 4 + code when the first stage's cascade bit is 0, and 132 + code when it is 1. The latency rises strictly across all 256 combinations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one period is one quarter-gate delay unit |
| rstN | input | 1 | Active-low synchronous reset |
| sigIn | input | 1 | Signal to be delayed |
| sigEn | input | 1 | High to admit `sigIn` into the chain |
| selCode | input | 7 | Delay select code |
| cascSel | input | 1 | Cascade request bit |
| latchEn | input | 1 | High to load `selCode` and `cascSel` |
| forceMin | input | 1 | Forces the minimum setting |
| forceMax | input | 1 | Forces the maximum setting |
| sigOut | output | 1 | Delayed signal |
| cascOut | output | 1 | Stored cascade bit |
| cascOutN | output | 1 | Inverse of the stored cascade bit |

## Verification
Every cycle, the assertions check the override patterns, their priority, loading and holding of the register, that the cascade bit is preserved under the maximum override, the tap-range bound, and that the output stays quiet once no admitted edge can remain in the chain. The exact cycle latency for every code, the stored state that persists after an override is released, and the monotonic behaviour of a two-stage chain across the cascade boundary can only be shown by the bench's pulse measurements. The bench sweeps all 128 codes with the chain's cascade bit both low and high.

// File: rtl/tapdly_pkg.sv
package tapdly_pkg;
  localparam int CODE_W    = 7;
  localparam int FRAC_W    = 2;
  localparam int UNIT_W    = CODE_W + 1;
  localparam int MAX_UNITS = 1 << CODE_W;
  localparam int DEPTH     = MAX_UNITS + 1;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              extraStep;
  } tapStrobe_t;
endpackage

// File: rtl/tapdly_ctrl.sv
module tapdly_ctrl import tapdly_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] selCode,
  input  logic              cascSel,
  input  logic              latchEn,
  input  logic              forceMin,
  input  logic              forceMax,
  output tapStrobe_t        strobe,
  output logic              cascBit
);
  localparam logic [CODE_W-1:0] MAX_CODE = ~CODE_W'((1 << FRAC_W) - 1);

  logic [CODE_W-1:0] codeQ;
  logic              extraQ;
  logic              cascQ;

  always_ff @(posedge clk) begin
    if (!rstN || forceMin) begin
      codeQ  <= '0;
      extraQ <= 1'b0;
      cascQ  <= 1'b0;
    end else if (forceMax) begin
      codeQ  <= MAX_CODE;
      extraQ <= 1'b1;
    end else if (latchEn) begin
      codeQ  <= selCode;
      extraQ <= 1'b0;
      cascQ  <= cascSel;
    end
  end

  assign strobe.code      = codeQ;
  assign strobe.extraStep = extraQ;
  assign cascBit          = cascQ;

  AST_MIN_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    forceMin |=> (strobe.code == '0 && !strobe.extraStep && !cascBit)); // R4
  AST_MAX_PATTERN: assert property (@(posedge clk) disable iff (!rstN)
    (forceMax && !forceMin) |=> (strobe.code == MAX_CODE && strobe.extraStep)); // R5
  AST_MAX_KEEPS_CASC: assert property (@(posedge clk) disable iff (!rstN)
    (forceMax && !forceMin) |=> $stable(cascBit)); // R5
  AST_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (latchEn && !forceMin && !forceMax) |=>
      (strobe.code == $past(selCode) && cascBit == $past(cascSel))); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!latchEn && !forceMin && !forceMax) |=>
      ($stable(strobe.code) && $stable(cascBit) && $stable(strobe.extraStep))); // R3
  AST_OVERRIDE_BLOCKS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (forceMin || forceMax) |=> !strobe.extraStep == !$past(forceMax && !forceMin)); // R6
endmodule

// File: rtl/tapdly_path.sv
module tapdly_path import tapdly_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sigIn,
  input  logic       sigEn,
  input  tapStrobe_t strobe,
  output logic       sigOut
);
  localparam int          IDLE_LIM = DEPTH + 2;
  localparam int          IDLE_W   = $clog2(IDLE_LIM + 1);
  localparam [UNIT_W-1:0] STEP     = UNIT_W'(1 << FRAC_W);

  logic [DEPTH-1:0]  chainQ;
  logic [UNIT_W-1:0] tapIdx;
  logic              outQ;

  always_comb begin
    tapIdx = UNIT_W'(strobe.code);
    if (strobe.extraStep) tapIdx = tapIdx + STEP;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chainQ <= '0;
      outQ   <= 1'b0;
    end else begin
      chainQ <= {chainQ[DEPTH-2:0], sigIn & sigEn};
      outQ   <= chainQ[tapIdx];
    end
  end

  assign sigOut = outQ;

  logic [IDLE_W-1:0] idleCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                    idleCnt <= IDLE_W'(IDLE_LIM);
    else if (sigIn && sigEn)      idleCnt <= '0;
    else if (idleCnt != IDLE_W'(IDLE_LIM)) idleCnt <= idleCnt + 1'b1;
  end

  AST_TAP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    tapIdx <= UNIT_W'(MAX_UNITS)); // R5
  AST_QUIET_WHEN_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (idleCnt == IDLE_W'(IDLE_LIM)) |-> !sigOut); // R8
endmodule

// File: rtl/tapDelayStage.sv
module tapDelayStage import tapdly_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sigIn,
  input  logic              sigEn,
  input  logic [CODE_W-1:0] selCode,
  input  logic              cascSel,
  input  logic              latchEn,
  input  logic              forceMin,
  input  logic              forceMax,
  output logic              sigOut,
  output logic              cascOut,
  output logic              cascOutN
);
  tapStrobe_t strobe;
  logic       cascBit;

  tapdly_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .selCode(selCode), .cascSel(cascSel),
    .latchEn(latchEn), .forceMin(forceMin), .forceMax(forceMax),
    .strobe(strobe), .cascBit(cascBit)
  );

  tapdly_path u_path (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .sigEn(sigEn),
    .strobe(strobe), .sigOut(sigOut)
  );

  assign cascOut  = cascBit;
  assign cascOutN = ~cascBit;

  AST_RESET_OUTS: assert property (@(posedge clk)
    !rstN |=> (!sigOut && !cascOut && cascOutN)); // R1
  AST_CASC_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    cascOut ^ cascOutN); // R7
endmodule

// File: tb/test_tapDelayStage.sv
module test_tapDelayStage;
  localparam int WIN = 280;
  localparam int BASE = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sigIn = 1'b0, sigEn = 1'b1;
  logic [6:0] selCode = '0;
  logic cascSel = 1'b0, latchEn = 1'b0, forceMin = 1'b0, forceMax = 1'b0;
  logic sigOut, cascOut, cascOutN;
  logic latchEnC = 1'b0, d7C = 1'b0;
  logic aOut, aCasc, aCascN, bOut, bCasc, bCascN;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tapDelayStage i_tapDelayStage (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .sigEn(sigEn), .selCode(selCode),
    .cascSel(cascSel), .latchEn(latchEn), .forceMin(forceMin), .forceMax(forceMax),
    .sigOut(sigOut), .cascOut(cascOut), .cascOutN(cascOutN));

  tapDelayStage i_chainA (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .sigEn(sigEn), .selCode(selCode),
    .cascSel(d7C), .latchEn(latchEnC), .forceMin(1'b0), .forceMax(aCasc),
    .sigOut(aOut), .cascOut(aCasc), .cascOutN(aCascN));

  tapDelayStage i_chainB (
    .clk(clk), .rstN(rstN), .sigIn(aOut), .sigEn(1'b1), .selCode(selCode),
    .cascSel(1'b0), .latchEn(latchEnC), .forceMin(aCascN), .forceMax(1'b0),
    .sigOut(bOut), .cascOut(bCasc), .cascOutN(bCascN));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic loadCode(input int c, input bit d7s, input bit d7c);
    @(negedge clk);
    selCode = 7'(c); cascSel = d7s; d7C = d7c; latchEn = 1'b1; latchEnC = 1'b1;
    repeat (3) @(negedge clk);
    latchEn = 1'b0; latchEnC = 1'b0;
    selCode = ~7'(c); cascSel = ~d7s; d7C = ~d7c;
  endtask

  task automatic measure(input bit enPulse, input bit dropEn, output int latS, output int latC);
    @(negedge clk);
    sigEn = enPulse; sigIn = 1'b1;
    latS = -1; latC = -1;
    for (int k = 1; k <= WIN; k++) begin
      @(negedge clk);
      if (k == 1) begin
        sigIn = 1'b0;
        if (dropEn) sigEn = 1'b0;
      end
      if (sigOut && latS < 0) latS = k;
      if (bOut && latC < 0) latC = k;
    end
    sigEn = 1'b1;
  endtask

  initial begin
    int ls, lc, prevC;
    repeat (5) @(negedge clk);
    check("R1 sigOut in reset", int'(sigOut), 0);
    check("R1 cascOut in reset", int'(cascOut), 0);
    check("R1 cascOutN in reset", int'(cascOutN), 1);
    rstN = 1'b1;
    measure(1, 0, ls, lc);
    check("R1 latency after reset", ls, BASE);

    prevC = -1;
    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < 128; c++) begin
        loadCode(c, c[0], d[0]);
        check("R7 cascOut follows stored bit", int'(cascOut), int'(c[0]));
        check("R7 cascOutN inverse", int'(cascOutN), int'(!c[0]));
        measure(1, 0, ls, lc);
        check("R2/R3 single-stage latency", ls, BASE + c);
        check("R9 chained latency", lc, (d == 0) ? 4 + c : 132 + c);
        check("R9 chain strictly rising", int'(lc > prevC), 1);
        prevC = lc;
      end
    end

    // R4 with R6: minimum override ignores the bus
    loadCode(40, 1, 0);
    @(negedge clk);
    forceMin = 1'b1; selCode = 7'd100; cascSel = 1'b1; latchEn = 1'b1;
    repeat (2) @(negedge clk);
    check("R4 cascOut cleared", int'(cascOut), 0);
    measure(1, 0, ls, lc);
    check("R6 bus ignored under forceMin", ls, BASE);
    forceMin = 1'b0; latchEn = 1'b0;
    measure(1, 0, ls, lc);
    check("R4 min setting persists", ls, BASE);

    // R5 maximum override
    loadCode(5, 1, 0);
    @(negedge clk);
    forceMax = 1'b1; selCode = 7'd0; cascSel = 1'b0; latchEn = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 cascade bit kept", int'(cascOut), 1);
    measure(1, 0, ls, lc);
    check("R5 max latency", ls, BASE + 128);
    forceMax = 1'b0; latchEn = 1'b0;
    measure(1, 0, ls, lc);
    check("R5 max setting persists", ls, BASE + 128);

    // R6 both overrides
    @(negedge clk);
    forceMin = 1'b1; forceMax = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 min wins cascOut", int'(cascOut), 0);
    measure(1, 0, ls, lc);
    check("R6 min wins latency", ls, BASE);
    forceMin = 1'b0; forceMax = 1'b0;

    // R8 enable gating
    loadCode(20, 0, 0);
    measure(0, 0, ls, lc);
    check("R8 gated pulse absent", ls, -1);
    measure(1, 1, ls, lc);
    check("R8 in-flight pulse still arrives", ls, BASE + 20);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule